// File: doc/BRIEF.md
# ISDN B-Channel Timeslot Port

This block moves one 8-bit B-channel sample per 8 kHz frame across a 2B+D style serial bus. Two bus layouts are supported. In the half-rate layout (GCI-like), every data bit lasts two bit-clock periods and the two B slots are each 16 bit clocks long. In the full-rate layout (IDL-like), every bit lasts one bit-clock period and the slots start at fixed edge counts after a one-clock-wide sync pulse. Only the slot picked by the channel strap is driven or captured. The transmit line is a tri-state pad: the block provides the data bit and a pad enable, and the enable is high only inside the picked slot.

The block runs on a system clock that is much faster than the bit clock. It samples the bit clock and frame sync, finds their edges, and counts bit-clock rising edges from each frame sync rising edge. The transmit byte is latched at frame start and sent MSB first. The received byte is assembled MSB first and shown with a one-cycle strobe. Two straps pick the layout and the channel. Each strap is sampled at every frame start and takes effect only once the same value has been seen at two frame starts in a row.

The controller state machine has four states. ST_HUNT means no sync has been seen since reset. ST_WAIT means the frame is running and the slot has not started. ST_SLOT means the line is driven. ST_DONE means the slot has ended. The transitions are:
- HUNT to WAIT on the first frame sync.
- WAIT to SLOT on the rising edge that starts the slot. In the half-rate layout with B1, this can be the same edge as the sync.
- SLOT to DONE on the falling edge that releases the line.
- Any state except HUNT goes to WAIT on every later frame sync.

Top module: `timeslot_port`

## Requirements
- R1: After reset, tx_en and rx_valid are 0. While no frame sync rising edge has been seen, tx_en stays 0 and rx_valid never pulses, whatever the bit clock does.
- R2: The straps strap_idl (1 = full-rate layout, 0 = half-rate layout) and strap_b2 (1 = B2, 0 = B1) are sampled at each frame sync rising edge. A sampled pair is used from the frame where the same pair was also sampled at the previous frame start. Until then the previous setting stays. After reset the setting is half-rate layout, B1.
- R3: tx_byte is latched at the frame sync rising edge. Changes to tx_byte later in the frame do not alter the bits sent in that frame.
- R4: Half-rate layout transmit. Rising edges are numbered from 0, where 0 is the edge that coincides with the sync rising edge. Bit k of the byte (k = 0 is the MSB) is on tx_d from rising edge 2k up to rising edge 2k+2 for B1. For B2 the span is 16+2k up to 18+2k.
- R5: Half-rate layout release. Falling edges are numbered from 1 after the sync. tx_en goes low at falling edge 16 (B1) or 32 (B2).
- R6: Half-rate layout receive. rx_d is captured on rising edge 2k+1 (B1) or 17+2k (B2) for bit k, MSB first.
- R7: Full-rate layout transmit. The first rising edge after the sync is edge 1. Bit k is driven from rising edge 1+k (B1) or 11+k (B2). tx_en goes low at falling edge 9 (B1) or 19 (B2); falling edge n is the one that follows rising edge n-1.
- R8: Full-rate layout receive. Bit k is captured on falling edge 2+k (B1) or 12+k (B2), MSB first.
- R9: After the last bit of the picked slot is captured, rx_byte holds the received byte and rx_valid is high for exactly one system clock cycle. There is one pulse per frame.
- R10: tx_en is low at all times outside the picked slot, including the whole of the other channel's slot. Data on rx_d in the other slot does not reach rx_byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Bus bit clock, sampled by clk |
| fsync | input | 1 | 8 kHz frame sync, sampled by clk |
| strap_idl | input | 1 | Layout strap: 1 full-rate, 0 half-rate |
| strap_b2 | input | 1 | Channel strap: 1 B2, 0 B1 |
| tx_byte | input | 8 | Sample to send, latched at frame start |
| rx_d | input | 1 | Serial receive data |
| tx_d | output | 1 | Serial transmit data bit for the pad |
| tx_en | output | 1 | Pad output enable; low means high impedance |
| rx_byte | output | 8 | Last received sample |
| rx_valid | output | 1 | One-cycle strobe when rx_byte is updated |

## Verification
The hardest situation to reach is the frame in which a strap has just changed but is not yet in force. In that frame the block must keep the old layout and slot, even though the new strap value is already on its pins. The bench gets there by changing the straps before a frame sync and then generating that frame in the old layout, with expectations set from the old setting. The new layout is only checked from the next frame on. A second awkward case is the half-rate B1 slot, where the sync edge and the first data edge are the same rising edge. This case is exercised right after reset and again after a return from the full-rate layout.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_WAIT,
        ST_SLOT,
        ST_DONE
    } tsp_state_e;

    typedef struct packed {
        logic idl;   // 1: full-rate layout, 0: half-rate layout
        logic b2;    // 1: second B slot, 0: first B slot
    } tsp_cfg_t;

endpackage

// File: rtl/tsp_edge.sv
module tsp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
    assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/tsp_strap.sv
module tsp_strap
    import tsp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     frame,
    input  logic     strap_idl,
    input  logic     strap_b2,
    output tsp_cfg_t cfg_now
);
    tsp_cfg_t sample, hist, cfg_q;
    logic     hist_ok;
    logic     adopt;

    always_comb begin
        sample.idl = strap_idl;
        sample.b2  = strap_b2;
        adopt      = frame && hist_ok && (sample == hist);
        cfg_now    = adopt ? sample : cfg_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist    <= '0;
            hist_ok <= 1'b0;
            cfg_q   <= '0;
        end else if (frame) begin
            hist    <= sample;
            hist_ok <= 1'b1;
            cfg_q   <= cfg_now;
        end
    end

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame |=> $stable(cfg_q));
endmodule

// File: rtl/timeslot_port.sv
module timeslot_port
    import tsp_pkg::*;
#(
    parameter int BYTE_W       = 8,
    parameter int CNT_W        = 6,
    parameter int GCI_B2_START = 16,
    parameter int IDL_B1_START = 1,
    parameter int IDL_B2_START = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk,
    input  logic              fsync,
    input  logic              strap_idl,
    input  logic              strap_b2,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              rx_d,
    output logic              tx_d,
    output logic              tx_en,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid
);
    localparam logic [CNT_W-1:0] IDX_MAX  = '1;
    localparam logic [CNT_W-1:0] SPAN_IDL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] SPAN_GCI = CNT_W'(2 * BYTE_W);
    localparam logic [CNT_W-1:0] S_GCI_B1 = '0;
    localparam logic [CNT_W-1:0] S_GCI_B2 = CNT_W'(GCI_B2_START);
    localparam logic [CNT_W-1:0] S_IDL_B1 = CNT_W'(IDL_B1_START);
    localparam logic [CNT_W-1:0] S_IDL_B2 = CNT_W'(IDL_B2_START);

    logic       bclk_rise, bclk_fall, frame, fs_fall_unused;
    tsp_cfg_t   cfg;
    tsp_state_e state, st_base, st_next;

    logic [CNT_W-1:0]  ridx, ridx_now, slot_s, slot_e, rel;
    logic [BYTE_W-1:0] sh, src, rx_sh;
    logic in_slot_r, tx_step, gci_cap, idl_cap, cap_now, last_cap, release_now, active;

    tsp_edge u_bclk_edge (.clk(clk), .rst_n(rst_n), .lvl(bclk),
                          .rise(bclk_rise), .fall(bclk_fall));
    tsp_edge u_fs_edge   (.clk(clk), .rst_n(rst_n), .lvl(fsync),
                          .rise(frame), .fall(fs_fall_unused));
    tsp_strap u_strap    (.clk(clk), .rst_n(rst_n), .frame(frame),
                          .strap_idl(strap_idl), .strap_b2(strap_b2), .cfg_now(cfg));

    // slot geometry and edge decode
    always_comb begin
        if (cfg.idl) slot_s = cfg.b2 ? S_IDL_B2 : S_IDL_B1;
        else         slot_s = cfg.b2 ? S_GCI_B2 : S_GCI_B1;
        slot_e   = slot_s + (cfg.idl ? SPAN_IDL : SPAN_GCI) - 1'b1;
        ridx_now = frame ? '0 : ((ridx == IDX_MAX) ? IDX_MAX : ridx + 1'b1);
        rel      = ridx_now - slot_s;
        in_slot_r = (ridx_now >= slot_s) && (ridx_now <= slot_e);
        st_base  = frame ? ST_WAIT : state;
        active   = (st_base == ST_WAIT) || (st_base == ST_SLOT);
        tx_step  = active && bclk_rise && in_slot_r && (cfg.idl || !rel[0]);
        gci_cap  = !cfg.idl && bclk_rise && in_slot_r && rel[0];
        idl_cap  = cfg.idl && bclk_fall && (ridx >= slot_s) && (ridx <= slot_e);
        cap_now  = active && (gci_cap || idl_cap);
        last_cap = cap_now && (gci_cap ? (ridx_now == slot_e) : (ridx == slot_e));
        release_now = bclk_fall && (ridx == slot_e) && (st_base == ST_SLOT);
        src      = frame ? tx_byte : sh;
    end

    // next state
    always_comb begin
        st_next = st_base;
        unique case (st_base)
            ST_HUNT: st_next = ST_HUNT;
            ST_WAIT: if (tx_step)     st_next = ST_SLOT;
            ST_SLOT: if (release_now) st_next = ST_DONE;
            ST_DONE: st_next = ST_DONE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= st_next;
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ridx     <= IDX_MAX;
            sh       <= '0;
            tx_d     <= 1'b0;
            tx_en    <= 1'b0;
            rx_sh    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (frame || bclk_rise) ridx <= ridx_now;
            if (frame) begin
                sh    <= tx_byte;
                tx_en <= 1'b0;
            end
            if (tx_step) begin
                tx_d  <= src[BYTE_W-1];
                sh    <= {src[BYTE_W-2:0], 1'b0};
                tx_en <= 1'b1;
            end
            if (release_now) tx_en <= 1'b0;
            if (cap_now) rx_sh <= {rx_sh[BYTE_W-2:0], rx_d};
            if (last_cap) begin
                rx_byte  <= {rx_sh[BYTE_W-2:0], rx_d};
                rx_valid <= 1'b1;
            end
        end
    end

    // R1
    hunt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT) |-> (!tx_en && !rx_valid));
    // R10
    drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(bclk_rise));
    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en) && !$past(bclk_rise)) |-> $stable(tx_d));
    // R5
    release_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> ($past(bclk_fall) || $past(frame)));
    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

// File: tb/test_timeslot_port.sv
module test_timeslot_port;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       bclk = 1'b0, fsync = 1'b0, strap_idl = 1'b0, strap_b2 = 1'b0, rx_d = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_d, tx_en, rx_valid;
    logic [7:0] rx_byte;

    int checks = 0, failures = 0, vcnt = 0;
    bit done = 1'b0;

    timeslot_port i_timeslot_port (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
        .strap_idl(strap_idl), .strap_b2(strap_b2), .tx_byte(tx_byte), .rx_d(rx_d),
        .tx_d(tx_d), .tx_en(tx_en), .rx_byte(rx_byte), .rx_valid(rx_valid));

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (rx_valid) vcnt++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int slot_start(input bit idl, input bit b2);
        return idl ? (b2 ? 11 : 1) : (b2 ? 16 : 0);
    endfunction

    function automatic bit en_exp(input bit idl, input bit b2, input int r, input bit lo);
        int s = slot_start(idl, b2);
        int e = s + (idl ? 8 : 16) - 1;
        return (r >= s) && (r <= e) && !(lo && r == e);
    endfunction

    function automatic int bit_idx(input bit idl, input int r, input int s);
        return idl ? (r - s) : (r - s) / 2;
    endfunction

    function automatic logic rx_drive(input bit idl, input bit b2, input logic [7:0] rxb, input int r);
        int s = slot_start(idl, b2);
        int o = slot_start(idl, !b2);
        int sp = idl ? 8 : 16;
        if (r >= s && r < s + sp) return rxb[7 - bit_idx(idl, r, s)];
        if (r >= o && r < o + sp) return ~rxb[7 - bit_idx(idl, r, o)];
        return 1'b0;
    endfunction

    // one frame; idl/b2 are the layout the design is expected to use
    task automatic run_frame(input bit idl, input bit b2, input logic [7:0] txb,
                             input logic [7:0] rxb, input string tag);
        int en_err = 0, d_err = 0, first = 0, last;
        int s = slot_start(idl, b2);
        vcnt = 0;
        @(negedge clk);
        tx_byte = txb;
        if (idl) begin
            bclk = 1'b1;
            repeat (2) @(negedge clk);
            fsync = 1'b1;
            repeat (2) @(negedge clk);
            bclk = 1'b0;
            repeat (2) @(negedge clk);
            fsync = 1'b0;
            repeat (2) @(negedge clk);
            first = 1;
            last = 24;
        end else begin
            last = 31;
        end
        for (int r = first; r <= last; r++) begin
            bclk = 1'b1;
            if (!idl && r == 0) fsync = 1'b1;
            rx_d = rx_drive(idl, b2, rxb, r);
            if (r == 2) tx_byte = ~txb;
            repeat (3) @(negedge clk);
            if (tx_en !== en_exp(idl, b2, r, 1'b0)) en_err++;
            if (en_exp(idl, b2, r, 1'b0) && tx_d !== txb[7 - bit_idx(idl, r, s)]) d_err++;
            @(negedge clk);
            bclk = 1'b0;
            if (!idl && r == 0) fsync = 1'b0;
            repeat (3) @(negedge clk);
            if (tx_en !== en_exp(idl, b2, r, 1'b1)) en_err++;
            if (en_exp(idl, b2, r, 1'b1) && tx_d !== txb[7 - bit_idx(idl, r, s)]) d_err++;
            @(negedge clk);
        end
        if (idl) begin
            check(en_err == 0, {tag, " R7 R10 enable window"}, en_err, 0);
            check(d_err == 0,  {tag, " R7 R3 transmit bits"}, d_err, 0);
            check(rx_byte === rxb, {tag, " R8 receive byte"}, rx_byte, rxb);
        end else begin
            check(en_err == 0, {tag, " R5 R10 enable window"}, en_err, 0);
            check(d_err == 0,  {tag, " R4 R3 transmit bits"}, d_err, 0);
            check(rx_byte === rxb, {tag, " R6 receive byte"}, rx_byte, rxb);
        end
        check(vcnt == 1, {tag, " R9 one valid strobe"}, vcnt, 1);
    endtask

    task automatic t_reset();
        int en_seen = 0;
        vcnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_en === 1'b0 && rx_valid === 1'b0, "R1 reset outputs", {tx_en, rx_valid}, 0);
        for (int i = 0; i < 20; i++) begin
            bclk = ~bclk;
            rx_d = i[0];
            repeat (4) @(negedge clk);
            if (tx_en !== 1'b0) en_seen++;
        end
        bclk = 1'b0;
        repeat (4) @(negedge clk);
        check(en_seen == 0, "R1 no drive before sync", en_seen, 0);
        check(vcnt == 0, "R1 no strobe before sync", vcnt, 0);
    endtask

    task automatic t_gci_b1();
        run_frame(1'b0, 1'b0, 8'hA5, 8'h3C, "gci b1 first");
        run_frame(1'b0, 1'b0, 8'h00, 8'hFF, "gci b1 edge bytes");
    endtask

    task automatic t_gci_b2();
        strap_b2 = 1'b1;
        run_frame(1'b0, 1'b0, 8'h96, 8'h81, "R2 gci b2 pending");
        run_frame(1'b0, 1'b1, 8'h5A, 8'hC3, "gci b2");
    endtask

    task automatic t_idl_b2();
        strap_idl = 1'b1;
        run_frame(1'b0, 1'b1, 8'h12, 8'hE7, "R2 idl pending");
        run_frame(1'b1, 1'b1, 8'hF0, 8'h0F, "idl b2");
    endtask

    task automatic t_idl_b1();
        strap_b2 = 1'b0;
        run_frame(1'b1, 1'b1, 8'h69, 8'h24, "R2 idl b1 pending");
        run_frame(1'b1, 1'b0, 8'hFF, 8'h00, "idl b1");
        run_frame(1'b1, 1'b0, 8'hC6, 8'h9B, "idl b1 again");
    endtask

    task automatic t_back_to_gci();
        strap_idl = 1'b0;
        run_frame(1'b1, 1'b0, 8'h33, 8'h77, "R2 gci return pending");
        run_frame(1'b0, 1'b0, 8'hE1, 8'h4D, "gci b1 return");
    endtask

    initial begin
        t_reset();
        t_gci_b1();
        t_gci_b2();
        t_idl_b2();
        t_idl_b1();
        t_back_to_gci();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule